// File: doc/BRIEF.md
# Debug Hold Mode Controller

This block keeps track of what the processor core is doing: executing user code, sleeping in wait, sitting in stop, stepping one instruction, or frozen in a debug-hold state where it only services serial debug commands. It watches the mode strap when reset is released, the halt-instruction and breakpoint strobes, the wait-instruction strobe, the stop indicator and the interrupt request. From these it drives a hold line that freezes the core's instruction flow.

A serial debug front end decodes each incoming command into a class and presents it with a one-cycle strobe. The block answers every strobe one cycle later with either an accept pulse or an error pulse. The answer depends on the class and on the current state. A status read that arrives while the core is in a low-power state is accepted, but it carries a flag instead of performing any memory access. A stop command issued during wait wakes the core straight into debug hold. The block also issues a one-cycle request to clear the interrupt mask when the core enters wait. It issues a one-cycle release pulse when a single-instruction trace starts.

Top module: `dbg_hold_ctrl`

## Requirements
- R1: While reset is asserted the state output reads 5 (boot) and the hold output is high. At the first clock edge after reset release the strap decides the next state: strap low gives state 3 (debug hold) and strap high gives state 0 (run).
- R2: In run, any of these enters debug hold at the next clock edge: a halt-instruction strobe, a hit on either breakpoint input, or an accepted class-3 command (stop-to-debug). Debug entry wins over a wait strobe in the same cycle.
- R3: In debug hold the hold output stays high. Halt and breakpoint strobes have no effect there. The state is left only through an accepted class-6 command (resume), which gives run, or through class 5 (see R10).
- R4: Command classes are coded as follows: 0 memory access, 1 memory access with status, 2 debug register access, 3 stop-to-debug, 4 core register access, 5 trace, 6 resume. Class 7 and any larger code is rejected in every state. In run, classes 0 to 3 are accepted and classes 4 to 6 are rejected. The answer appears one cycle after the strobe.
- R5: In debug hold, classes 0 to 6 are all accepted.
- R6: A wait strobe in run moves the state to 1 (wait) and raises the hold output. The mask-clear output pulses high for exactly the one cycle in which the state first reads wait.
- R7: An interrupt request during wait returns the state to run at the next edge.
- R8: In wait only classes 1 and 3 are accepted. Class 1 is answered with the low-power flag set. Class 3 moves the state to debug hold and takes priority over a simultaneous interrupt.
- R9: A high stop indicator in run gives state 2 (stop). The state returns to run when the indicator falls. In stop, class 1 is accepted with the low-power flag set and every other class is rejected.
- R10: Class 5 in debug hold gives state 4 (step). In step the hold output is low and the step-release output pulses for one cycle. The step-done input then returns the state to debug hold.
- R11: A rejected command produces a single-cycle error pulse, never together with an accept pulse. It leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Mode strap, low requests debug hold at reset release |
| cmd_valid_i | input | 1 | One-cycle strobe of a decoded serial command |
| cmd_class_i | input | CLS_W | Class of the strobed command |
| halt_insn_i | input | 1 | Halt instruction executed |
| bkpt_i | input | BKPT_N | Breakpoint hits (serial-debug and on-chip debug) |
| wait_insn_i | input | 1 | Wait instruction executed |
| stop_i | input | 1 | Core is in stop |
| irq_i | input | 1 | Interrupt request |
| step_done_i | input | 1 | Traced instruction completed |
| state_o | output | 3 | Current state code |
| cpu_hold_o | output | 1 | Core instruction flow frozen |
| cmd_ack_o | output | 1 | Command accepted |
| cmd_err_o | output | 1 | Command rejected |
| lp_flag_o | output | 1 | Accepted status command found the core in a low-power state |
| imask_clr_o | output | 1 | Clear the interrupt mask |
| step_go_o | output | 1 | Release the core for one instruction |

## Verification
The hardest situations to reach are those where two events compete in one cycle. One is a stop-to-debug command that arrives together with the interrupt that would otherwise wake the core from wait. Another is a halt strobe that lands together with a wait strobe. The bench first walks the block into wait through a normal wait strobe. It then raises the command strobe and the interrupt on the same falling edge, so both are sampled at one rising edge. The trace path is reached only from debug hold. It is checked across the whole release and completion handshake, including the cycle where the release pulse must already have dropped.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

   typedef enum logic [2:0] {
      ST_RUN  = 3'd0,
      ST_WAIT = 3'd1,
      ST_STOP = 3'd2,
      ST_HOLD = 3'd3,
      ST_STEP = 3'd4,
      ST_BOOT = 3'd5
   } dhc_state_e;

   localparam int unsigned CMD_MEM    = 0;
   localparam int unsigned CMD_MEMST  = 1;
   localparam int unsigned CMD_DREG   = 2;
   localparam int unsigned CMD_BGND   = 3;
   localparam int unsigned CMD_CPUREG = 4;
   localparam int unsigned CMD_TRACE  = 5;
   localparam int unsigned CMD_GO     = 6;

   localparam int unsigned LAST_PASSIVE = CMD_BGND;
   localparam int unsigned LAST_ACTIVE  = CMD_GO;

endpackage

// File: rtl/dhc_cmd_check.sv
module dhc_cmd_check
   import dhc_pkg::*;
#(
   parameter int unsigned CLS_W = 3
) (
   input  dhc_state_e       st,
   input  logic             valid,
   input  logic [CLS_W-1:0] cls,
   output logic             accept,
   output logic             lp_flag,
   output logic             bgnd_ok,
   output logic             go_ok,
   output logic             trace_ok
);

   logic passive, active, is_memst, is_bgnd;

   always_comb begin
      passive  = (cls <= CLS_W'(LAST_PASSIVE));
      active   = (cls > CLS_W'(LAST_PASSIVE)) && (cls <= CLS_W'(LAST_ACTIVE));
      is_memst = (cls == CLS_W'(CMD_MEMST));
      is_bgnd  = (cls == CLS_W'(CMD_BGND));
      unique case (st)
         ST_RUN, ST_STEP: accept = passive;
         ST_HOLD:         accept = passive || active;
         ST_WAIT:         accept = is_memst || is_bgnd;
         ST_STOP:         accept = is_memst;
         default:         accept = 1'b0;
      endcase
      lp_flag  = is_memst && (st == ST_WAIT || st == ST_STOP);
      bgnd_ok  = valid && accept && is_bgnd;
      go_ok    = valid && accept && (cls == CLS_W'(CMD_GO));
      trace_ok = valid && accept && (cls == CLS_W'(CMD_TRACE));
   end

endmodule

// File: rtl/dhc_fsm.sv
module dhc_fsm
   import dhc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strap,
   input  logic       bgnd_ok,
   input  logic       go_ok,
   input  logic       trace_ok,
   input  logic       halt,
   input  logic       bkpt_any,
   input  logic       wait_insn,
   input  logic       stop,
   input  logic       irq,
   input  logic       step_done,
   output dhc_state_e st_q,
   output logic       imask_clr_q,
   output logic       step_go_q
);

   dhc_state_e st_d;
   logic       imask_d, step_d;

   always_comb begin
      st_d    = st_q;
      imask_d = 1'b0;
      step_d  = 1'b0;
      unique case (st_q)
         ST_BOOT: st_d = strap ? ST_RUN : ST_HOLD;
         ST_RUN: begin
            if (bgnd_ok || halt || bkpt_any) begin
               st_d = ST_HOLD;
            end else if (stop) begin
               st_d = ST_STOP;
            end else if (wait_insn) begin
               st_d    = ST_WAIT;
               imask_d = 1'b1;
            end
         end
         ST_WAIT: begin
            if (bgnd_ok)  st_d = ST_HOLD;
            else if (irq) st_d = ST_RUN;
         end
         ST_STOP: if (!stop) st_d = ST_RUN;
         ST_HOLD: begin
            if (go_ok) begin
               st_d = ST_RUN;
            end else if (trace_ok) begin
               st_d   = ST_STEP;
               step_d = 1'b1;
            end
         end
         ST_STEP: if (step_done) st_d = ST_HOLD;
         default: st_d = ST_BOOT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_BOOT;
         imask_clr_q <= 1'b0;
         step_go_q   <= 1'b0;
      end else begin
         st_q        <= st_d;
         imask_clr_q <= imask_d;
         step_go_q   <= step_d;
      end
   end

endmodule

// File: rtl/dhc_resp.sv
module dhc_resp (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic accept,
   input  logic lp,
   output logic ack_q,
   output logic err_q,
   output logic lp_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         err_q <= 1'b0;
         lp_q  <= 1'b0;
      end else begin
         ack_q <= valid && accept;
         err_q <= valid && !accept;
         lp_q  <= valid && accept && lp;
      end
   end

endmodule

// File: rtl/dbg_hold_ctrl.sv
module dbg_hold_ctrl
   import dhc_pkg::*;
#(
   parameter int unsigned CLS_W  = 3,
   parameter int unsigned BKPT_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_i,
   input  logic             cmd_valid_i,
   input  logic [CLS_W-1:0] cmd_class_i,
   input  logic             halt_insn_i,
   input  logic [BKPT_N-1:0] bkpt_i,
   input  logic             wait_insn_i,
   input  logic             stop_i,
   input  logic             irq_i,
   input  logic             step_done_i,
   output logic [2:0]       state_o,
   output logic             cpu_hold_o,
   output logic             cmd_ack_o,
   output logic             cmd_err_o,
   output logic             lp_flag_o,
   output logic             imask_clr_o,
   output logic             step_go_o
);

   localparam int unsigned MIN_CLS_W = $clog2(LAST_ACTIVE + 1);

   if (CLS_W < MIN_CLS_W) begin : g_bad_cls_w
      $error("CLS_W too narrow for the command classes");
   end
   if (BKPT_N < 1) begin : g_bad_bkpt_n
      $error("BKPT_N must be at least 1");
   end

   logic [BKPT_N:0] bkpt_or;
   assign bkpt_or[0] = 1'b0;
   for (genvar g = 0; g < BKPT_N; g++) begin : g_bkpt
      assign bkpt_or[g+1] = bkpt_or[g] | bkpt_i[g];
   end

   dhc_state_e st;
   logic       accept, lp, bgnd_ok, go_ok, trace_ok;

   dhc_cmd_check #(.CLS_W(CLS_W)) i_cmd (
      .st       (st),
      .valid    (cmd_valid_i),
      .cls      (cmd_class_i),
      .accept   (accept),
      .lp_flag  (lp),
      .bgnd_ok  (bgnd_ok),
      .go_ok    (go_ok),
      .trace_ok (trace_ok)
   );

   dhc_fsm i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .strap       (strap_i),
      .bgnd_ok     (bgnd_ok),
      .go_ok       (go_ok),
      .trace_ok    (trace_ok),
      .halt        (halt_insn_i),
      .bkpt_any    (bkpt_or[BKPT_N]),
      .wait_insn   (wait_insn_i),
      .stop        (stop_i),
      .irq         (irq_i),
      .step_done   (step_done_i),
      .st_q        (st),
      .imask_clr_q (imask_clr_o),
      .step_go_q   (step_go_o)
   );

   dhc_resp i_resp (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (cmd_valid_i),
      .accept (accept),
      .lp     (lp),
      .ack_q  (cmd_ack_o),
      .err_q  (cmd_err_o),
      .lp_q   (lp_flag_o)
   );

   assign state_o    = st;
   assign cpu_hold_o = (st != ST_RUN) && (st != ST_STEP);

endmodule

// File: rtl/dhc_checker.sv
module dhc_checker
   import dhc_pkg::*;
#(
   parameter int unsigned CLS_W  = 3,
   parameter int unsigned BKPT_N = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid_i,
   input logic [CLS_W-1:0]  cmd_class_i,
   input logic              halt_insn_i,
   input logic [BKPT_N-1:0] bkpt_i,
   input logic              stop_i,
   input logic              irq_i,
   input logic              step_done_i,
   input logic [2:0]        state_o,
   input logic              cpu_hold_o,
   input logic              cmd_ack_o,
   input logic              cmd_err_o,
   input logic              lp_flag_o,
   input logic              imask_clr_o,
   input logic              step_go_o
);

   p_bkpt_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_RUN && (halt_insn_i || (|bkpt_i))) |=> state_o == ST_HOLD);

   p_go_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_HOLD && cmd_valid_i && cmd_class_i == CLS_W'(CMD_GO))
      |=> (state_o == ST_RUN && cmd_ack_o));

   p_hold_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_HOLD && !(cmd_valid_i && (cmd_class_i == CLS_W'(CMD_GO) ||
                                               cmd_class_i == CLS_W'(CMD_TRACE))))
      |=> (state_o == ST_HOLD && cpu_hold_o));

   p_active_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_RUN && cmd_valid_i && cmd_class_i >= CLS_W'(CMD_CPUREG) &&
       cmd_class_i <= CLS_W'(CMD_GO)) |=> cmd_err_o);

   p_wait_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      imask_clr_o |-> (state_o == ST_WAIT && $past(state_o) == ST_RUN));

   p_irq_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_WAIT && irq_i && !(cmd_valid_i && cmd_class_i == CLS_W'(CMD_BGND)))
      |=> state_o == ST_RUN);

   p_lp_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lp_flag_o |-> cmd_ack_o);

   p_stop_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_STOP && stop_i && cmd_valid_i && cmd_class_i != CLS_W'(CMD_MEMST))
      |=> (cmd_err_o && state_o == ST_STOP));

   p_step_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      step_go_o |=> !step_go_o);

   p_step_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_STEP && step_done_i) |=> state_o == ST_HOLD);

   p_resp_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_ack_o && cmd_err_o));

endmodule

bind dbg_hold_ctrl dhc_checker #(.CLS_W(CLS_W), .BKPT_N(BKPT_N)) i_dhc_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid_i (cmd_valid_i),
   .cmd_class_i (cmd_class_i),
   .halt_insn_i (halt_insn_i),
   .bkpt_i      (bkpt_i),
   .stop_i      (stop_i),
   .irq_i       (irq_i),
   .step_done_i (step_done_i),
   .state_o     (state_o),
   .cpu_hold_o  (cpu_hold_o),
   .cmd_ack_o   (cmd_ack_o),
   .cmd_err_o   (cmd_err_o),
   .lp_flag_o   (lp_flag_o),
   .imask_clr_o (imask_clr_o),
   .step_go_o   (step_go_o)
);

// File: tb/test_dbg_hold_ctrl.sv
module test_dbg_hold_ctrl;
   import dhc_pkg::*;

   logic       clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
   logic       cmd_valid = 1'b0, halt = 1'b0, wait_insn = 1'b0;
   logic       stop = 1'b0, irq = 1'b0, step_done = 1'b0;
   logic [2:0] cmd_class = '0;
   logic [1:0] bkpt = '0;
   logic [2:0] state_o;
   logic       cpu_hold_o, cmd_ack_o, cmd_err_o, lp_flag_o, imask_clr_o, step_go_o;

   int  checks = 0, fails = 0;
   bit  finished = 1'b0;

   typedef struct {bit ack; bit lp; string req;} exp_t;
   exp_t sbq[$];

   always #10 clk = ~clk;

   dbg_hold_ctrl #(.CLS_W(3), .BKPT_N(2)) i_dbg_hold_ctrl (
      .clk(clk), .rst_n(rst_n), .strap_i(strap), .cmd_valid_i(cmd_valid),
      .cmd_class_i(cmd_class), .halt_insn_i(halt), .bkpt_i(bkpt),
      .wait_insn_i(wait_insn), .stop_i(stop), .irq_i(irq), .step_done_i(step_done),
      .state_o(state_o), .cpu_hold_o(cpu_hold_o), .cmd_ack_o(cmd_ack_o),
      .cmd_err_o(cmd_err_o), .lp_flag_o(lp_flag_o), .imask_clr_o(imask_clr_o),
      .step_go_o(step_go_o)
   );

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_state(logic [2:0] exp, string req);
      chk(state_o == exp, req, "state", state_o, exp);
   endtask

   // driver: strobe one command, push the expected answer for the monitor
   task automatic issue(int c, bit a, bit lp, string req, bit with_irq = 1'b0);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_class = c[2:0];
      irq       = with_irq;
      sbq.push_back('{ack: a, lp: lp, req: req});
      @(negedge clk);
      cmd_valid = 1'b0;
      irq       = 1'b0;
   endtask

   // 0 halt, 1 bkpt0, 2 bkpt1, 3 wait, 4 irq, 5 step done, 6 halt with wait
   task automatic pulse_in(int which);
      @(negedge clk);
      case (which)
         0: halt = 1'b1;
         1: bkpt[0] = 1'b1;
         2: bkpt[1] = 1'b1;
         3: wait_insn = 1'b1;
         4: irq = 1'b1;
         5: step_done = 1'b1;
         default: begin halt = 1'b1; wait_insn = 1'b1; end
      endcase
      @(negedge clk);
      halt = 1'b0; bkpt = '0; wait_insn = 1'b0; irq = 1'b0; step_done = 1'b0;
   endtask

   task automatic do_reset(bit s, logic [2:0] exp);
      @(negedge clk);
      rst_n = 1'b0;
      strap = s;
      repeat (2) @(negedge clk);
      check_state(3'(ST_BOOT), "R1");
      chk(cpu_hold_o == 1'b1, "R1", "hold in reset", cpu_hold_o, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check_state(exp, "R1");
   endtask

   task automatic resume();
      issue(CMD_GO, 1, 0, "R3");
      check_state(3'(ST_RUN), "R3");
   endtask

   // monitor: pop and compare as answers appear
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n && (cmd_ack_o || cmd_err_o)) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R11", "unexpected answer", 1, 0);
         end else begin
            e = sbq.pop_front();
            chk(cmd_ack_o == e.ack, e.req, "accept", cmd_ack_o, e.ack);
            chk(cmd_err_o == !e.ack, e.req, "error", cmd_err_o, !e.ack);
            chk(lp_flag_o == e.lp, e.req, "lp flag", lp_flag_o, e.lp);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset(1'b0, 3'(ST_HOLD));                       // R1 strap low
      // R3: halt and breakpoints ignored in hold
      pulse_in(0);
      check_state(3'(ST_HOLD), "R3");
      pulse_in(2);
      check_state(3'(ST_HOLD), "R3");
      chk(cpu_hold_o == 1'b1, "R3", "hold", cpu_hold_o, 1);
      // R5: every defined class accepted in hold
      issue(CMD_MEM, 1, 0, "R5");
      issue(CMD_CPUREG, 1, 0, "R5");
      issue(7, 0, 0, "R4");
      resume();
      chk(cpu_hold_o == 1'b0, "R3", "hold after resume", cpu_hold_o, 0);
      // R4 / R11 in run
      issue(CMD_CPUREG, 0, 0, "R4");
      check_state(3'(ST_RUN), "R11");
      issue(CMD_TRACE, 0, 0, "R4");
      issue(CMD_GO, 0, 0, "R4");
      check_state(3'(ST_RUN), "R11");
      issue(7, 0, 0, "R4");
      issue(CMD_MEM, 1, 0, "R4");
      issue(CMD_MEMST, 1, 0, "R4");
      issue(CMD_DREG, 1, 0, "R4");
      // R2 debug entry causes
      pulse_in(0);
      check_state(3'(ST_HOLD), "R2");
      resume();
      pulse_in(1);
      check_state(3'(ST_HOLD), "R2");
      resume();
      pulse_in(2);
      check_state(3'(ST_HOLD), "R2");
      resume();
      issue(CMD_BGND, 1, 0, "R2");
      check_state(3'(ST_HOLD), "R2");
      // R10 trace
      issue(CMD_TRACE, 1, 0, "R10");
      check_state(3'(ST_STEP), "R10");
      chk(step_go_o == 1'b1, "R10", "step release", step_go_o, 1);
      chk(cpu_hold_o == 1'b0, "R10", "hold in step", cpu_hold_o, 0);
      @(negedge clk);
      chk(step_go_o == 1'b0, "R10", "step release drop", step_go_o, 0);
      check_state(3'(ST_STEP), "R10");
      pulse_in(5);
      check_state(3'(ST_HOLD), "R10");
      resume();
      // R6 / R7 / R8 wait
      pulse_in(3);
      check_state(3'(ST_WAIT), "R6");
      chk(imask_clr_o == 1'b1, "R6", "mask clear", imask_clr_o, 1);
      chk(cpu_hold_o == 1'b1, "R6", "hold in wait", cpu_hold_o, 1);
      @(negedge clk);
      chk(imask_clr_o == 1'b0, "R6", "mask clear drop", imask_clr_o, 0);
      issue(CMD_MEM, 0, 0, "R8");
      check_state(3'(ST_WAIT), "R11");
      issue(CMD_MEMST, 1, 1, "R8");
      issue(CMD_GO, 0, 0, "R8");
      pulse_in(4);
      check_state(3'(ST_RUN), "R7");
      pulse_in(3);
      check_state(3'(ST_WAIT), "R6");
      issue(CMD_BGND, 1, 0, "R8", 1'b1);
      check_state(3'(ST_HOLD), "R8");
      resume();
      // R2 priority over wait
      pulse_in(6);
      check_state(3'(ST_HOLD), "R2");
      chk(imask_clr_o == 1'b0, "R2", "mask clear", imask_clr_o, 0);
      resume();
      // R9 stop
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      check_state(3'(ST_STOP), "R9");
      issue(CMD_MEMST, 1, 1, "R9");
      issue(CMD_BGND, 0, 0, "R9");
      check_state(3'(ST_STOP), "R9");
      issue(CMD_MEM, 0, 0, "R9");
      @(negedge clk);
      stop = 1'b0;
      @(negedge clk);
      check_state(3'(ST_RUN), "R9");
      // R1 strap high
      do_reset(1'b1, 3'(ST_RUN));
      repeat (2) @(negedge clk);
      chk(sbq.size() == 0, "R11", "missing answers", sbq.size(), 0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule